// File: doc/BRIEF.md
# Edge-Stepped Phase Offset Controller

This block keeps a signed phase offset for a generated clock as an unsigned phase index. The index is stored modulo the number of fine steps in one output period, and that number depends on the ratio mode. Each rising edge on an asynchronous step strobe moves the index by one fine step. An asynchronous direction input chooses which way the step goes: it either delays or advances the output. A downstream phase selector or NCO reads the index. A one-cycle pulse marks each time the index wraps around the period.

Both asynchronous inputs are brought into the system clock domain before use. Two behaviours are intentional. First, the last strobe edge of every group of 32 accepted edges leaves the phase where it is. Second, a rate monitor raises a one-cycle flag when two strobe edges arrive with no rising edge on the direction input between them. Changing the mode clears the index. The hold mode freezes it.

Top module: `phase_step_ctrl`

## Requirements
- R1: Each accepted strobe rising edge changes `phase_o` by exactly one step, no more and no less.
- R2: If the synchronised direction is 1 when the strobe edge is taken, the step advances the output and the index goes down by one. If the direction is 0, the step delays the output and the index goes up by one.
- R3: The modulus is selected by `mode_i`. Code 0 (multiply) gives 384 steps, code 1 (divide by 2) gives 3072, code 2 (divide by 3) gives 6144 and code 3 (divide by 4) gives 12288. `phase_o` never exceeds modulus minus one.
- R4: A delay step from modulus minus one goes to 0, and an advance step from 0 goes to modulus minus one. Each of these wraps pulses `wrap_o` high for exactly one cycle, in the same cycle as the new index.
- R5: A counter counts the strobe edges taken in modes 0 to 3. The 32nd edge of each group of 32 leaves the index unchanged, and the next edge starts a new group.
- R6: `rate_err_o` pulses for one cycle when a strobe edge arrives and no direction rising edge has occurred since the previous strobe edge. A direction rising edge in the same cycle as the strobe edge counts as occurring in between. The first strobe edge after reset is never flagged, and a flagged step is still applied.
- R7: Mode codes 4 to 7 select hold mode. In hold mode, strobe edges leave the index unchanged and do not advance the group counter.
- R8: A change of `mode_i` forces `phase_o` to 0 on the next clock edge. A strobe edge that falls in that same cycle is dropped.
- R9: While `rst_n` is low, `phase_o` is 0, `wrap_o` is 0 and `rate_err_o` is 0. The group counter and the rate monitor are cleared, so the next group starts from its first edge.
- R10: The strobe and direction inputs each pass through a two-flop synchroniser. A strobe that rises before clock edge k changes `phase_o` at edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| mode_i | input | 3 | Ratio mode: 0 multiply, 1 divide by 2, 2 divide by 3, 3 divide by 4, 4 to 7 hold |
| strobe_i | input | 1 | Asynchronous step strobe; each rising edge requests one step |
| dir_i | input | 1 | Asynchronous direction: 1 advances the output, 0 delays it |
| phase_o | output | 14 | Current phase index, from 0 to modulus minus 1 |
| wrap_o | output | 1 | One-cycle pulse when the index wraps |
| rate_err_o | output | 1 | One-cycle pulse on a strobe edge that had no direction edge before it |

## Verification
The assertions assume three things about the inputs. `mode_i` is synchronous to `clk`. Each strobe level and each direction level is held for several clock cycles, so that synchronised edges are at least three cycles apart. At each strobe edge, the direction input has already settled at the level that selects the step. The stimulus keeps to these rules: every input level is held for at least four cycles, the direction is set before the strobe rises, and the strobe is never changed at a clock edge. The only exception is the one sequence that deliberately leaves out the direction edge to provoke the rate flag.

// File: rtl/phase_step_pkg.sv
package phase_step_pkg;

  typedef enum logic [2:0] {
    MD_MUL  = 3'd0,
    MD_DIV2 = 3'd1,
    MD_DIV3 = 3'd2,
    MD_DIV4 = 3'd3,
    MD_HOLD = 3'd4
  } ratio_mode_e;

  // Codes 4..7 all freeze the index.
  function automatic logic mode_is_hold(input logic [2:0] m);
    return m[2];
  endfunction

endpackage

// File: rtl/phase_step_sync.sv
module phase_step_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/phase_step_edges.sv
module phase_step_edges #(
  parameter int GROUP_LEN = 32,
  localparam int GRP_W    = (GROUP_LEN > 2) ? $clog2(GROUP_LEN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_s_i,
  input  logic dir_s_i,
  input  logic accept_i,
  output logic stb_edge_o,
  output logic dir_rise_o,
  output logic step_o
);

  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUP_LEN - 1);

  logic             stb_q, dir_q;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic             grp_en;
  logic             grp_last;

  always_comb begin
    stb_edge_o = stb_s_i & ~stb_q;
    dir_rise_o = dir_s_i & ~dir_q;
    grp_last   = (grp_q == GRP_LAST);
    grp_en     = stb_edge_o & accept_i;
    step_o     = grp_en & ~grp_last;
    grp_d      = grp_q;
    if (grp_en) grp_d = grp_last ? '0 : grp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      dir_q <= 1'b0;
      grp_q <= '0;
    end else begin
      stb_q <= stb_s_i;
      dir_q <= dir_s_i;
      if (grp_en) grp_q <= grp_d;
    end
  end

endmodule

// File: rtl/phase_step_rate.sv
module phase_step_rate (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_edge_i,
  input  logic dir_rise_i,
  output logic err_o
);

  logic armed_q, armed_d;
  logic seen_q, seen_d;
  logic err_q, err_d;

  always_comb begin
    err_d   = stb_edge_i & armed_q & ~(seen_q | dir_rise_i);
    armed_d = armed_q | stb_edge_i;
    seen_d  = stb_edge_i ? 1'b0 : (seen_q | dir_rise_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      seen_q  <= seen_d;
      err_q   <= err_d;
    end
  end

  assign err_o = err_q;

endmodule

// File: rtl/phase_step_acc.sv
module phase_step_acc
  import phase_step_pkg::*;
#(
  parameter int PH_W     = 14,
  parameter int MOD_MUL  = 384,
  parameter int MOD_DIV2 = 3072,
  parameter int MOD_DIV3 = 6144,
  parameter int MOD_DIV4 = 12288
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      mode_i,
  input  logic            step_i,
  input  logic            dir_i,
  output logic [PH_W-1:0] phase_o,
  output logic            wrap_o,
  output logic [2:0]      mode_q_o,
  output logic [PH_W-1:0] last_idx_o,
  output logic            accept_o
);

  localparam logic [PH_W-1:0] LAST_MUL  = PH_W'(MOD_MUL  - 1);
  localparam logic [PH_W-1:0] LAST_DIV2 = PH_W'(MOD_DIV2 - 1);
  localparam logic [PH_W-1:0] LAST_DIV3 = PH_W'(MOD_DIV3 - 1);
  localparam logic [PH_W-1:0] LAST_DIV4 = PH_W'(MOD_DIV4 - 1);

  logic [2:0]      mode_q, mode_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            wrap_q, wrap_d;
  logic [PH_W-1:0] last_idx;
  logic            mode_chg;

  always_comb begin
    unique case (mode_q)
      MD_MUL:  last_idx = LAST_MUL;
      MD_DIV2: last_idx = LAST_DIV2;
      MD_DIV3: last_idx = LAST_DIV3;
      MD_DIV4: last_idx = LAST_DIV4;
      default: last_idx = LAST_MUL;
    endcase
  end

  always_comb begin
    mode_chg = (mode_i != mode_q);
    accept_o = ~mode_chg & ~mode_is_hold(mode_q);
    mode_d   = mode_q;
    phase_d  = phase_q;
    wrap_d   = 1'b0;
    if (mode_chg) begin
      mode_d  = mode_i;
      phase_d = '0;
    end else if (step_i && accept_o) begin
      if (dir_i) begin
        if (phase_q == '0) begin
          phase_d = last_idx;
          wrap_d  = 1'b1;
        end else begin
          phase_d = phase_q - 1'b1;
        end
      end else begin
        if (phase_q == last_idx) begin
          phase_d = '0;
          wrap_d  = 1'b1;
        end else begin
          phase_d = phase_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_MUL;
      phase_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      phase_q <= phase_d;
      wrap_q  <= wrap_d;
    end
  end

  assign phase_o    = phase_q;
  assign wrap_o     = wrap_q;
  assign mode_q_o   = mode_q;
  assign last_idx_o = last_idx;

endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl #(
  parameter int STEPS_MUL   = 384,
  parameter int DIV2_FACTOR = 8,
  parameter int DIV3_FACTOR = 16,
  parameter int DIV4_FACTOR = 32,
  parameter int GROUP_LEN   = 32,
  parameter int SYNC_STAGES = 2,
  localparam int MOD_DIV2   = STEPS_MUL * DIV2_FACTOR,
  localparam int MOD_DIV3   = STEPS_MUL * DIV3_FACTOR,
  localparam int MOD_DIV4   = STEPS_MUL * DIV4_FACTOR,
  localparam int PH_W       = $clog2(MOD_DIV4)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      mode_i,
  input  logic            strobe_i,
  input  logic            dir_i,
  output logic [PH_W-1:0] phase_o,
  output logic            wrap_o,
  output logic            rate_err_o
);

  logic [1:0]      raw_in;
  logic [1:0]      sync_out;
  logic            stb_s, dir_s;
  logic            stb_edge, dir_rise, step;
  logic            accept;
  logic [2:0]      mode_q;
  logic [PH_W-1:0] last_idx;

  assign raw_in = {dir_i, strobe_i};
  assign stb_s  = sync_out[0];
  assign dir_s  = sync_out[1];

  phase_step_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  phase_step_edges #(
    .GROUP_LEN (GROUP_LEN)
  ) u_edges (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb_s_i    (stb_s),
    .dir_s_i    (dir_s),
    .accept_i   (accept),
    .stb_edge_o (stb_edge),
    .dir_rise_o (dir_rise),
    .step_o     (step)
  );

  phase_step_rate u_rate (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb_edge_i (stb_edge),
    .dir_rise_i (dir_rise),
    .err_o      (rate_err_o)
  );

  phase_step_acc #(
    .PH_W     (PH_W),
    .MOD_MUL  (STEPS_MUL),
    .MOD_DIV2 (MOD_DIV2),
    .MOD_DIV3 (MOD_DIV3),
    .MOD_DIV4 (MOD_DIV4)
  ) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .step_i     (step),
    .dir_i      (dir_s),
    .phase_o    (phase_o),
    .wrap_o     (wrap_o),
    .mode_q_o   (mode_q),
    .last_idx_o (last_idx),
    .accept_o   (accept)
  );

endmodule

// File: rtl/phase_step_chk.sv
module phase_step_chk #(
  parameter int PH_W = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      mode_i,
  input logic [2:0]      mode_q,
  input logic [PH_W-1:0] phase_o,
  input logic [PH_W-1:0] last_idx,
  input logic            wrap_o,
  input logic            rate_err_o,
  input logic            stb_edge
);

  AST_PHASE_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o <= last_idx); // R3

  AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(phase_o) && ($past(mode_i) == $past(mode_q))) |->
      ((phase_o == PH_W'($past(phase_o) + 1'b1)) ||
       (phase_o == PH_W'($past(phase_o) - 1'b1)) || wrap_o)); // R1

  AST_WRAP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> ((phase_o == '0) || (phase_o == last_idx))); // R4

  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> !wrap_o); // R4

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[2] && (mode_i == mode_q)) |=> $stable(phase_o)); // R7

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != mode_q) |=> (phase_o == '0)); // R8

  AST_ERR_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rate_err_o |-> $past(stb_edge)); // R6

endmodule

bind phase_step_ctrl phase_step_chk #(.PH_W(PH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .mode_q     (mode_q),
  .phase_o    (phase_o),
  .last_idx   (last_idx),
  .wrap_o     (wrap_o),
  .rate_err_o (rate_err_o),
  .stb_edge   (stb_edge)
);

// File: tb/phase_step_ctrl_tb.sv
module phase_step_ctrl_tb;

  localparam int PW    = 14;
  localparam int GROUP = 32;

  logic          clk;
  logic          rst_n;
  logic [2:0]    mode;
  logic          stb;
  logic          dir;
  logic [PW-1:0] phase;
  logic          wrap;
  logic          err;

  phase_step_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .strobe_i   (stb),
    .dir_i      (dir),
    .phase_o    (phase),
    .wrap_o     (wrap),
    .rate_err_o (err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    int    ph;
    int    wraps;
    int    errs;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  int   wrap_cnt = 0;
  int   err_cnt = 0;
  bit   done = 1'b0;

  int   m_phase, m_grp, m_wraps, m_errs;
  bit   m_armed;

  function automatic int mod_of(input logic [2:0] m);
    case (m)
      3'd0:    return 384;
      3'd1:    return 3072;
      3'd2:    return 6144;
      3'd3:    return 12288;
      default: return 384;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  // pulse counters for the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (wrap) wrap_cnt++;
      if (err)  err_cnt++;
    end
  end

  // monitor: pops expected items and compares
  initial begin
    forever begin : mon
      exp_t e;
      @(negedge clk);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check({e.tag, " phase"}, int'(phase), e.ph);
        check({e.tag, " wraps"}, wrap_cnt, e.wraps);
        check({e.tag, " rate flags"}, err_cnt, e.errs);
      end
    end
  end

  task automatic push(input string tag);
    sb_q.push_back('{m_phase, m_wraps, m_errs, tag});
    repeat (2) @(negedge clk);
  endtask

  task automatic step(input bit d, input bit rate_ok, input string tag);
    int old_ph;
    int md;
    old_ph = m_phase;
    md = mod_of(mode);
    if (rate_ok) begin
      @(negedge clk); dir = 1'b0;
      repeat (4) @(negedge clk); dir = 1'b1;
      repeat (4) @(negedge clk); dir = d;
      repeat (4) @(negedge clk);
    end else begin
      @(negedge clk); dir = d;
      repeat (4) @(negedge clk);
    end
    // model
    if (m_armed && !rate_ok) m_errs++;
    m_armed = 1'b1;
    if (mode < 3'd4) begin
      if (m_grp == GROUP - 1) begin
        m_grp = 0;
      end else begin
        m_grp++;
        if (d) begin
          if (m_phase == 0) begin m_phase = md - 1; m_wraps++; end
          else m_phase--;
        end else begin
          if (m_phase == md - 1) begin m_phase = 0; m_wraps++; end
          else m_phase++;
        end
      end
    end
    stb = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R10 no change before third edge", int'(phase), old_ph);
    @(posedge clk);
    @(negedge clk);
    check({tag, " (R1 step on third edge)"}, int'(phase), m_phase);
    repeat (2) @(negedge clk);
    stb = 1'b0;
    repeat (4) @(negedge clk);
    push(tag);
  endtask

  task automatic set_mode(input logic [2:0] m, input string tag);
    @(negedge clk);
    if (m != mode) m_phase = 0;
    mode = m;
    repeat (3) @(negedge clk);
    push(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    stb   = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 phase in reset", int'(phase), 0);
    check("R9 wrap in reset", int'(wrap), 0);
    check("R9 rate flag in reset", int'(err), 0);
    m_phase = 0;
    m_grp   = 0;
    m_armed = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    push(tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; mode = 3'd0; stb = 1'b0; dir = 1'b0;
    m_phase = 0; m_grp = 0; m_wraps = 0; m_errs = 0; m_armed = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset phase", int'(phase), 0);
    check("R9 reset wrap", int'(wrap), 0);
    check("R9 reset rate flag", int'(err), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    push("R9 after release");

    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R2 delay step");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R2 advance step");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R4 advance across zero");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, "R4 delay across top");
    step(1'b0, 1'b1, "R5 32nd edge ignored");
    check("R5 index after ignored edge", int'(phase), 19);

    set_mode(3'd1, "R8 mode change clears");
    step(1'b1, 1'b1, "R3 div2 wrap down");
    check("R3 div2 top index", int'(phase), 3071);
    step(1'b0, 1'b1, "R3 div2 wrap up");
    set_mode(3'd2, "R8 mode change clears");
    step(1'b1, 1'b1, "R3 div3 wrap down");
    check("R3 div3 top index", int'(phase), 6143);
    step(1'b0, 1'b1, "R3 div3 wrap up");
    set_mode(3'd3, "R8 mode change clears");
    step(1'b1, 1'b1, "R3 div4 wrap down");
    check("R3 div4 top index", int'(phase), 12287);
    set_mode(3'd4, "R8 clear on entering hold");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R7 hold ignores strobe");
    set_mode(3'd0, "R8 back to multiply");

    step(1'b0, 1'b1, "R6 step with direction edge");
    step(1'b0, 1'b0, "R6 step without direction edge");
    step(1'b0, 1'b1, "R6 step with direction edge again");

    do_reset("R9 mid-run reset");
    for (int i = 0; i < GROUP; i++) step(1'b0, 1'b1, "R5 fresh group after reset");
    check("R5 group restarted by reset", int'(phase), GROUP - 1);

    repeat (4) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule